// File: doc/BRIEF.md
# Radix-8 SRT Digit-Recurrence Divider

This block divides an unsigned fixed-point dividend by a normalized divisor. It retires one radix-8 quotient digit per iteration. Digits are drawn from the full signed set -7..+7. Each step scales the partial remainder by eight and subtracts the digit times the divisor. That digit multiple is never produced by a multiplier. Each digit magnitude is split into two signed powers of two, so the multiple is two shifted copies of the divisor joined by one adder or subtractor.

Each digit is chosen by comparing a truncated estimate of the scaled residual against fourteen thresholds. The thresholds are formed from the six leading divisor bits. Quotient digits are gathered on the fly in a pair of registers that hold Q and Q-1, so no carry-propagate conversion is needed at the end. In a final cycle, a negative last residual is corrected: the divisor is added back to the remainder and the Q-1 register is used as the quotient.

Operands enter through a valid/ready handshake. Back-pressure is applied while a division is running: `in_ready` is low, and an offered operand pair waits. Results leave on a single-cycle `out_valid` strobe. This output has no ready signal, so the consumer must take the result when it is flagged. The result stays on the outputs until the next result replaces it.

Top module: `srt8_divider`

## Requirements
- R1: An operand pair is taken on a clock edge where `in_valid` and `in_ready` are both 1. From the next cycle, `in_ready` stays 0 until the cycle in which `out_valid` is 1, and in that cycle it is 1 again.
- R2: `out_valid` is 1 for exactly one cycle, and that cycle begins K+1 clock edges after the transfer edge (7 for the default K=6).
- R3: With dividend X and divisor D (bit W-1 of D set), `quotient` equals floor(X·2^(3K-1) / D), given as a 3K-bit unsigned integer.
- R4: `remainder` equals X·2^(3K) − quotient·2D, and it always lies in [0, 2D).
- R5: Every digit lies in -7..+7 and is applied as the sum or difference of two power-of-two multiples of the divisor. After every iteration, the internal residual magnitude does not exceed 2D (the divisor in residual units).
- R6: While `in_ready` is 0, `in_valid`, `dividend` and `divisor` have no effect. The running division finishes with its own operands, and no extra result is produced.
- R7: `quotient` and `remainder` keep their values in every cycle where `out_valid` is 0.
- R8: During and directly after reset, `in_ready` is 1, `out_valid` is 0, and `quotient` and `remainder` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operand pair offered |
| in_ready | output | 1 | Block idle and able to take operands |
| dividend | input | W | Unsigned dividend X |
| divisor | input | W | Normalized divisor D, MSB must be 1 |
| out_valid | output | 1 | One-cycle strobe marking a new result |
| quotient | output | 3K | floor(X·2^(3K-1)/D) |
| remainder | output | W+1 | Non-negative final remainder, below 2D |

## Verification
The hardest case to reach from the ports is the correction path, because it runs only when the last residual is negative. It can also hide behind a result that merely looks plausible. Many pseudo-random divisors spread across the normalized range, together with dividends at zero, just below the divisor, equal to it and at full scale, make sign changes in the final residual frequent. Each quotient/remainder pair is then checked exactly against integer arithmetic. Operands offered while the unit is busy are verified by presenting a conflicting pair mid-run and confirming that the original result emerges unchanged and that no extra result follows.

// File: rtl/srt8_pkg.sv
package srt8_pkg;

  // signed radix-8 digit, range -7..+7
  typedef logic signed [3:0] digit_t;

  // magnitude split into two power-of-two terms: A (+) and B (+ or -)
  typedef struct packed {
    logic       a_on;
    logic [1:0] a_sh;
    logic       b_on;
    logic [1:0] b_sh;
    logic       b_neg;
  } term_t;

  function automatic term_t split_digit(input logic [2:0] m);
    term_t t;
    t = '0;
    case (m)
      3'd1: begin t.a_on = 1'b1; t.a_sh = 2'd0; end
      3'd2: begin t.a_on = 1'b1; t.a_sh = 2'd1; end
      3'd3: begin t.a_on = 1'b1; t.a_sh = 2'd1; t.b_on = 1'b1; t.b_sh = 2'd0; end
      3'd4: begin t.a_on = 1'b1; t.a_sh = 2'd2; end
      3'd5: begin t.a_on = 1'b1; t.a_sh = 2'd2; t.b_on = 1'b1; t.b_sh = 2'd0; end
      3'd6: begin t.a_on = 1'b1; t.a_sh = 2'd2; t.b_on = 1'b1; t.b_sh = 2'd1; end
      3'd7: begin
        t.a_on = 1'b1; t.a_sh = 2'd3; t.b_on = 1'b1; t.b_sh = 2'd0; t.b_neg = 1'b1;
      end
      default: t = '0;
    endcase
    return t;
  endfunction

endpackage

// File: rtl/srt8_digit_sel.sv
// Digit selection: truncated 8*w estimate compared against thresholds
// (k - 1/2) * dtop for k = -6..7, dtop = leading six divisor bits.
module srt8_digit_sel
  import srt8_pkg::*;
#(
  parameter int W  = 16,
  parameter int RW = W + 6
) (
  input  logic signed [RW-1:0] res,
  input  logic        [5:0]    dtop,
  output digit_t               q
);

  localparam int SH   = W - 8;   // residual units -> 2^-6 units of 8w
  localparam int NCMP = 14;

  logic signed [RW-1:0] est2;
  logic [NCMP-1:0]      ge;
  logic [3:0]           n_ge;

  assign est2 = (res >>> SH) <<< 1;

  genvar i;
  generate
    for (i = 0; i < NCMP; i++) begin : g_cmp
      localparam int C = 2 * (i - 6) - 1;
      localparam logic signed [RW-1:0] CV = C;
      logic signed [RW-1:0] thr;
      assign thr   = CV * $signed({{(RW-6){1'b0}}, dtop});
      assign ge[i] = (est2 >= thr);
    end
  endgenerate

  always_comb begin
    n_ge = '0;
    for (int j = 0; j < NCMP; j++) n_ge = n_ge + 4'(ge[j]);
  end

  assign q = digit_t'(n_ge - 4'd7);

endmodule

// File: rtl/srt8_multiple.sv
// |q| * dd formed from two shifted divisor copies and one adder/subtractor.
module srt8_multiple
  import srt8_pkg::*;
#(
  parameter int DW = 17
) (
  input  digit_t          q,
  input  logic [DW-1:0]   dd,
  output logic [DW+2:0]   mag
);

  localparam int MW = DW + 3;

  logic [2:0]    m;
  term_t         t;
  logic [MW-1:0] dx, ta, tb;

  always_comb begin
    m   = q[3] ? 3'(-q) : q[2:0];
    t   = split_digit(m);
    dx  = MW'(dd);
    ta  = t.a_on ? (dx << t.a_sh) : '0;
    tb  = t.b_on ? (dx << t.b_sh) : '0;
    mag = t.b_neg ? (ta - tb) : (ta + tb);
  end

endmodule

// File: rtl/srt8_otf.sv
// On-the-fly quotient conversion: Q and Q-1 registers, 3 bits per step.
module srt8_otf
  import srt8_pkg::*;
#(
  parameter int QW = 18
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          step,
  input  digit_t        q,
  output logic [QW-1:0] q_acc,
  output logic [QW-1:0] qm_acc
);

  logic [2:0] dec;
  logic       pos;

  assign dec = 3'(q - 4'sd1);
  assign pos = !q[3] && (q != 4'sd0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q_acc  <= '0;
      qm_acc <= '1;
    end else if (clear) begin
      q_acc  <= '0;
      qm_acc <= '1;
    end else if (step) begin
      q_acc  <= {(q[3] ? qm_acc[QW-4:0] : q_acc[QW-4:0]), q[2:0]};
      qm_acc <= {(pos  ? q_acc[QW-4:0]  : qm_acc[QW-4:0]), dec};
    end
  end

endmodule

// File: rtl/srt8_divider.sv
module srt8_divider
  import srt8_pkg::*;
#(
  parameter int W = 16,
  parameter int K = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  output logic             in_ready,
  input  logic [W-1:0]     dividend,
  input  logic [W-1:0]     divisor,
  output logic             out_valid,
  output logic [3*K-1:0]   quotient,
  output logic [W:0]       remainder
);

  localparam int QW = 3 * K;
  localparam int DW = W + 1;
  localparam int RW = W + 6;
  localparam int CW = $clog2(K) + 1;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIX} st_t;

  st_t                  state;
  logic signed [RW-1:0] res, res8, res_nx, mag_x;
  logic [DW-1:0]        dd, rem_fix;
  logic [CW-1:0]        cnt;
  digit_t               q;
  logic [DW+2:0]        mag;
  logic [QW-1:0]        q_acc, qm_acc;
  logic                 accept, running;

  assign in_ready = (state == S_IDLE);
  assign accept   = in_valid && in_ready;
  assign running  = (state == S_RUN);

  srt8_digit_sel #(.W(W), .RW(RW)) u_sel (
    .res  (res),
    .dtop (dd[DW-1:DW-6]),
    .q    (q)
  );

  srt8_multiple #(.DW(DW)) u_mul (
    .q   (q),
    .dd  (dd),
    .mag (mag)
  );

  srt8_otf #(.QW(QW)) u_otf (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (accept),
    .step   (running),
    .q      (q),
    .q_acc  (q_acc),
    .qm_acc (qm_acc)
  );

  assign res8    = res <<< 3;
  assign mag_x   = $signed({{(RW-DW-3){1'b0}}, mag});
  assign res_nx  = q[3] ? (res8 + mag_x) : (res8 - mag_x);
  assign rem_fix = res[DW-1:0] + dd;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_IDLE;
      res       <= '0;
      dd        <= '0;
      cnt       <= '0;
      quotient  <= '0;
      remainder <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= 1'b0;
      case (state)
        S_IDLE: begin
          if (accept) begin
            res   <= $signed({{(RW-W){1'b0}}, dividend});
            dd    <= {divisor, 1'b0};
            cnt   <= '0;
            state <= S_RUN;
          end
        end
        S_RUN: begin
          res <= res_nx;
          cnt <= cnt + 1'b1;
          if (cnt == CW'(K - 1)) state <= S_FIX;
        end
        S_FIX: begin
          if (res[RW-1]) begin
            quotient  <= qm_acc;
            remainder <= rem_fix;
          end else begin
            quotient  <= q_acc;
            remainder <= res[DW-1:0];
          end
          out_valid <= 1'b1;
          state     <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/srt8_divider_chk.sv
module srt8_divider_chk #(
  parameter int W = 16,
  parameter int K = 6
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 in_valid,
  input logic                 in_ready,
  input logic                 out_valid,
  input logic                 running,
  input logic [3*K-1:0]       quotient,
  input logic [W:0]           remainder,
  input logic signed [W+5:0]  res,
  input logic [W:0]           dd
);

  localparam int RW = W + 6;
  localparam int LW = $clog2(K + 3) + 1;

  logic [LW-1:0]        lat;
  logic                 track;
  logic signed [RW-1:0] ddx;

  assign ddx = $signed({5'b0, dd});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lat   <= '0;
      track <= 1'b0;
    end else if (in_valid && in_ready) begin
      lat   <= '0;
      track <= 1'b1;
    end else if (out_valid) begin
      track <= 1'b0;
    end else if (track) begin
      lat <= lat + 1'b1;
    end
  end

  p_accept_blocks_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> !in_ready);

  p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (track && lat == LW'(K + 1)));

  p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  p_rem_below_divisor_r4: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (remainder < dd));

  p_residual_bound_r5: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> ((res <= ddx) && (res >= -ddx)));

  p_busy_ignores_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> $stable(dd));

  p_outputs_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(quotient) && $stable(remainder)));

endmodule

bind srt8_divider srt8_divider_chk #(.W(W), .K(K)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .out_valid (out_valid),
  .running   (running),
  .quotient  (quotient),
  .remainder (remainder),
  .res       (res),
  .dd        (dd)
);

// File: tb/srt8_divider_test.sv
module srt8_divider_test;

  localparam int W  = 16;
  localparam int K  = 6;
  localparam int QW = 3 * K;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          in_valid;
  logic          in_ready;
  logic [W-1:0]  dividend;
  logic [W-1:0]  divisor;
  logic          out_valid;
  logic [QW-1:0] quotient;
  logic [W:0]    remainder;

  always #10 clk = ~clk;   // 50 MHz

  srt8_divider #(.W(W), .K(K)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .dividend(dividend), .divisor(divisor), .out_valid(out_valid),
    .quotient(quotient), .remainder(remainder)
  );

  typedef struct {
    longint q;
    longint r;
    longint acc;
  } exp_t;

  exp_t   sb[$];
  int     n_run = 0;
  int     n_fail = 0;
  longint pcnt = 0;
  longint last_q = 0;
  longint last_r = 0;
  bit     finished = 1'b0;

  always @(posedge clk) pcnt <= pcnt + 1;

  task automatic check(input string tag, input longint act, input longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // driver: compute expectation, offer operands, push when accepted
  task automatic send(input logic [W-1:0] x, input logic [W-1:0] d);
    exp_t e;
    e.q = (longint'(x) << (3*K-1)) / longint'(d);
    e.r = (longint'(x) << (3*K)) - e.q * 2 * longint'(d);
    @(negedge clk);
    in_valid = 1'b1;
    dividend = x;
    divisor  = d;
    while (!in_ready) @(negedge clk);
    e.acc = pcnt + 1;
    sb.push_back(e);
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 busy after transfer", longint'(in_ready), 0);
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        n_run++;
        n_fail++;
        $display("FAIL R6 unexpected result actual=%0d expected=none", quotient);
      end else begin
        exp_t e;
        e = sb.pop_front();
        check("R3,R5 quotient", longint'(quotient), e.q);
        check("R4 remainder", longint'(remainder), e.r);
        check("R2 latency", pcnt - e.acc, K + 1);
        check("R1 ready with result", longint'(in_ready), 1);
        last_q = e.q;
        last_r = e.r;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n    = 1'b0;
    in_valid = 1'b0;
    dividend = '0;
    divisor  = 16'h8000;
    repeat (3) @(negedge clk);
    check("R8 ready in reset", longint'(in_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R8 valid low", longint'(out_valid), 0);
    check("R8 quotient zero", longint'(quotient), 0);
    check("R8 remainder zero", longint'(remainder), 0);
    check("R8 ready", longint'(in_ready), 1);

    // boundary operands
    send(16'h0000, 16'h8000);
    send(16'hFFFF, 16'h8000);
    send(16'hFFFF, 16'hFFFF);
    send(16'h0001, 16'hFFFF);
    send(16'h7FFF, 16'h8000);
    send(16'h8000, 16'h8000);
    send(16'hABCD, 16'hABCE);
    send(16'hABCE, 16'hABCD);
    send(16'h5555, 16'hAAAA);
    send(16'h1234, 16'hC001);

    // R6: a conflicting pair offered mid-run must be ignored
    send(16'h03E8, 16'h9000);
    @(negedge clk);
    in_valid = 1'b1;
    dividend = 16'hFFFF;
    divisor  = 16'h8000;
    repeat (3) @(negedge clk);
    check("R6 still busy", longint'(in_ready), 0);
    in_valid = 1'b0;
    while (sb.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);

    // pseudo-random streaming, back to back
    for (int i = 0; i < 60; i++) begin
      logic [W-1:0] rx, rd;
      rx = W'($urandom_range(0, 65535));
      rd = W'($urandom_range(0, 32767)) | 16'h8000;
      send(rx, rd);
    end

    while (sb.size() != 0) @(negedge clk);
    repeat (8) @(negedge clk);
    check("R7 quotient held", longint'(quotient), last_q);
    check("R7 remainder held", longint'(remainder), last_r);
    check("R6 no extra result", longint'(out_valid), 0);
    check("R6 scoreboard empty", longint'(sb.size()), 0);

    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule